// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block holds a byte-wide configuration space that a host reaches through two adjacent byte I/O addresses: an index port and a data port. The host writes an index port byte to pick a register, then reads or writes that register through the data port. Out of reset the space is locked: the index port only feeds a key matcher, and the space opens only after a fixed four-byte key arrives on the index port in order.

Registers below index 0x30 are global: a logical-device selector, a 16-bit chip identifier, a revision byte and an exit register that locks the space again. Registers from 0x30 up form a window onto a small register bank kept for each logical device, and the selector picks which bank shows through. The logical devices themselves are not part of the block; only their register storage is.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked: a read of either port returns 0xFF, and rdValid is low until a read is presented.
- R2: The space unlocks once the bytes 0x87, 0x01, 0x55, 0x55 are written to the index port (INDEX_ADDR, default 0x2E) in that order; once unlocked, an index-port read returns the current index (0x00 right after unlocking).
- R3: An index-port byte that breaks the key order restarts matching; a 0x87 that breaks it counts as the first key byte, so 0x87 0x01 0x87 0x01 0x55 0x55 unlocks and 0x87 0x01 0x55 0x00 does not.
- R4: While locked, data-port writes have no effect on stored registers or on key matching, and data-port reads return 0xFF.
- R5: Index 0x20 reads CHIP_ID[15:8], index 0x21 reads CHIP_ID[7:0], index 0x22 reads CHIP_REV in bits 3:0 with bits 7:4 zero.
- R6: Index 0x07 holds the logical-device number; it reads back what was written and keeps its value across a relock.
- R7: Indices 0x30 to 0x30+BANK_REGS-1 access the bank of the selected logical device; each device keeps its own contents, a device number of NUM_LDN or more and an index past the bank read 0x00 and ignore writes.
- R8: Writing 0x02 to index 0x02 through the data port locks the space and clears the index to 0x00 and the key match.
- R9: Accesses to any address other than INDEX_ADDR and INDEX_ADDR+1 change no state and produce no rdValid.
- R10: A read on either port returns rdData with rdValid high in the cycle after the read strobe; rdValid is low in all other cycles.
- R11: Writing a value other than 0x02 to index 0x02 leaves the space unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | I/O address of the current access |
| busWr | input | 1 | Byte write strobe, one cycle per access |
| busRd | input | 1 | Byte read strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |
| rdValid | output | 1 | High for one cycle when rdData holds a read result |

## Verification
Every state change (key progress, index, register contents, relock) takes effect at the clock edge that samples the write, so the next access already sees it; read results land one edge after the read strobe. The bench drives each access for exactly one cycle from the falling edge and samples rdData and rdValid on the following falling edge, after that single registering edge. Effects of ignored writes are observed by later reads through the ports, never by peeking inside.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int KEY_LEN = 4;
  localparam logic [7:0] UNLOCK_KEY [KEY_LEN] = '{8'h87, 8'h01, 8'h55, 8'h55};

  localparam logic [7:0] IDX_EXIT   = 8'h02;
  localparam logic [7:0] EXIT_VALUE = 8'h02;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ID_HI  = 8'h20;
  localparam logic [7:0] IDX_ID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] BANK_BASE  = 8'h30;

  typedef enum logic [2:0] {
    KEY_WAIT0 = 3'd0,
    KEY_WAIT1 = 3'd1,
    KEY_WAIT2 = 3'd2,
    KEY_WAIT3 = 3'd3,
    CFG_OPEN  = 3'd4
  } cfg_state_e;

  typedef struct packed {
    logic       unlocked;
    logic       idxRd;
    logic       dataRd;
    logic       dataWr;
    logic [7:0] index;
  } cfg_stb_t;

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idxWr,
  input  logic       idxRd,
  input  logic       dataWr,
  input  logic       dataRd,
  input  logic [7:0] wdata,
  output cfg_stb_t   stb
);

  cfg_state_e state, stateNxt;
  logic [7:0] curIdx, idxNxt;

  always_comb begin
    stateNxt = state;
    idxNxt   = curIdx;
    if (state == CFG_OPEN) begin
      if (idxWr) begin
        idxNxt = wdata;
      end else if (dataWr && curIdx == IDX_EXIT && wdata == EXIT_VALUE) begin
        stateNxt = KEY_WAIT0;
        idxNxt   = '0;
      end
    end else if (idxWr) begin
      // key matching: advance on the expected byte, restart otherwise
      if (wdata == UNLOCK_KEY[state[1:0]]) begin
        stateNxt = (state == KEY_WAIT3) ? CFG_OPEN : cfg_state_e'(state + 3'd1);
      end else if (wdata == UNLOCK_KEY[0]) begin
        stateNxt = KEY_WAIT1;
      end else begin
        stateNxt = KEY_WAIT0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= KEY_WAIT0;
      curIdx <= '0;
    end else begin
      state  <= stateNxt;
      curIdx <= idxNxt;
    end
  end

  always_comb begin
    stb.unlocked = (state == CFG_OPEN);
    stb.idxRd    = idxRd;
    stb.dataRd   = dataRd;
    stb.dataWr   = dataWr;
    stb.index    = curIdx;
  end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_LDN   = 8,
  parameter int          BANK_REGS = 16,
  parameter logic [15:0] CHIP_ID   = 16'h8728,
  parameter logic [3:0]  CHIP_REV  = 4'h6
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfg_stb_t   stb,
  input  logic [7:0] wdata,
  output logic [7:0] rdData,
  output logic       rdValid
);

  localparam int BANK_AW = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;
  localparam int LDN_AW  = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

  logic [7:0] ldnReg;
  logic [7:0] bankMem [NUM_LDN][BANK_REGS];
  logic [7:0] offs;
  logic       bankHit, ldnValid, bankWr, ldnWr;
  logic [7:0] rdNext;

  assign offs     = stb.index - BANK_BASE;
  assign bankHit  = (stb.index >= BANK_BASE) && (int'(offs) < BANK_REGS);
  assign ldnValid = int'(ldnReg) < NUM_LDN;
  assign bankWr   = stb.unlocked && stb.dataWr && bankHit && ldnValid;
  assign ldnWr    = stb.unlocked && stb.dataWr && (stb.index == IDX_LDN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldnReg <= '0;
    end else if (ldnWr) begin
      ldnReg <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < NUM_LDN; d++) begin
        for (int r = 0; r < BANK_REGS; r++) begin
          bankMem[d][r] <= '0;
        end
      end
    end else if (bankWr) begin
      bankMem[ldnReg[LDN_AW-1:0]][offs[BANK_AW-1:0]] <= wdata;
    end
  end

  always_comb begin
    rdNext = 8'hFF;
    if (stb.idxRd) begin
      rdNext = stb.unlocked ? stb.index : 8'hFF;
    end else if (stb.unlocked) begin
      rdNext = 8'h00;
      if (bankHit) begin
        if (ldnValid) rdNext = bankMem[ldnReg[LDN_AW-1:0]][offs[BANK_AW-1:0]];
      end else begin
        case (stb.index)
          IDX_LDN:   rdNext = ldnReg;
          IDX_ID_HI: rdNext = CHIP_ID[15:8];
          IDX_ID_LO: rdNext = CHIP_ID[7:0];
          IDX_REV:   rdNext = {4'h0, CHIP_REV};
          default:   rdNext = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= 8'hFF;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.idxRd || stb.dataRd;
      if (stb.idxRd || stb.dataRd) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter int          NUM_LDN    = 8,
  parameter int          BANK_REGS  = 16,
  parameter logic [15:0] CHIP_ID    = 16'h8728,
  parameter logic [3:0]  CHIP_REV   = 4'h6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        rdData,
  output logic              rdValid
);

  localparam logic [ADDR_W-1:0] IDX_PORT  = INDEX_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] DATA_PORT = IDX_PORT + 1'b1;

  logic     idxHit, dataHit;
  cfg_stb_t ctlStb;

  assign idxHit  = (busAddr == IDX_PORT);
  assign dataHit = (busAddr == DATA_PORT);

  sio_cfg_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .idxWr  (busWr && idxHit),
    .idxRd  (busRd && idxHit),
    .dataWr (busWr && dataHit),
    .dataRd (busRd && dataHit),
    .wdata  (busWdata),
    .stb    (ctlStb)
  );

  sio_cfg_regs #(
    .NUM_LDN   (NUM_LDN),
    .BANK_REGS (BANK_REGS),
    .CHIP_ID   (CHIP_ID),
    .CHIP_REV  (CHIP_REV)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (ctlStb),
    .wdata   (busWdata),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID    = 16'h8728
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busWdata,
  input logic [7:0]        rdData,
  input logic              rdValid,
  input logic              unlocked,
  input logic [7:0]        curIndex
);

  logic idxHit, dataHit;
  assign idxHit  = (busAddr == INDEX_ADDR[ADDR_W-1:0]);
  assign dataHit = (busAddr == INDEX_ADDR[ADDR_W-1:0] + 1'b1);

  // R10: a port read is answered one cycle later
  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (idxHit || dataHit)) |=> rdValid);

  // R9, R10: no read strobe on the pair, no rdValid
  p_no_stray_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && (idxHit || dataHit)) |=> !rdValid);

  // R4: locked data reads return all ones
  p_locked_ff_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && busRd && dataHit) |=> (rdData == 8'hFF));

  // R2: unlocking only follows a final key byte on the index port
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(busWr && idxHit && busWdata == 8'h55));

  // R8: the exit write relocks and clears the index
  p_exit_relock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && busWr && dataHit && curIndex == 8'h02 && busWdata == 8'h02)
      |=> (!unlocked && curIndex == 8'h00));

  // R5: identifier high byte
  p_id_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && busRd && dataHit && curIndex == 8'h20) |=> (rdData == CHIP_ID[15:8]));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W     (ADDR_W),
  .INDEX_ADDR (INDEX_ADDR),
  .CHIP_ID    (CHIP_ID)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busRd    (busRd),
  .busWdata (busWdata),
  .rdData   (rdData),
  .rdValid  (rdValid),
  .unlocked (ctlStb.unlocked),
  .curIndex (ctlStb.index)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;

  localparam logic [15:0] IDX  = 16'h002E;
  localparam logic [15:0] DAT  = 16'h002F;
  localparam logic [15:0] FAR  = 16'h002D;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  rdData;
  logic        rdValid;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .rdData(rdData), .rdValid(rdValid)
  );

  // {isWrite, onDataPort, value, expected}
  localparam int NV = 30;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h87, 8'h00},   // R2 key
    {1'b1, 1'b0, 8'h01, 8'h00},
    {1'b1, 1'b0, 8'h55, 8'h00},
    {1'b1, 1'b0, 8'h55, 8'h00},
    {1'b1, 1'b0, 8'h20, 8'h00},   // R5 id high
    {1'b0, 1'b1, 8'h00, 8'h87},
    {1'b1, 1'b0, 8'h21, 8'h00},   // R5 id low
    {1'b0, 1'b1, 8'h00, 8'h28},
    {1'b1, 1'b0, 8'h22, 8'h00},   // R5 revision
    {1'b0, 1'b1, 8'h00, 8'h06},
    {1'b1, 1'b0, 8'h07, 8'h00},   // R6 select device 3
    {1'b1, 1'b1, 8'h03, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h03},
    {1'b1, 1'b0, 8'h30, 8'h00},   // R7 bank write
    {1'b1, 1'b1, 8'hA5, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'hA5},
    {1'b1, 1'b0, 8'h07, 8'h00},   // R7 other device is separate
    {1'b1, 1'b1, 8'h05, 8'h00},
    {1'b1, 1'b0, 8'h30, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b1, 8'h5A, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h5A},
    {1'b1, 1'b0, 8'h40, 8'h00},   // R7 past the bank
    {1'b1, 1'b1, 8'h99, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h07, 8'h00},   // R7 back to device 3
    {1'b1, 1'b1, 8'h03, 8'h00},
    {1'b1, 1'b0, 8'h30, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'hA5},
    {1'b0, 1'b0, 8'h00, 8'h30}    // R2 index readback
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wrPort(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdPort(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    check({tag, " valid (R10)"}, {7'd0, rdValid}, 8'd1);
    check(tag, rdData, exp);
  endtask

  task automatic sendKey(input logic [15:0] a);
    wrPort(a, 8'h87); wrPort(a, 8'h01); wrPort(a, 8'h55); wrPort(a, 8'h55);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdValid idle", {7'd0, rdValid}, 8'd0);
    rdPort(DAT, 8'hFF, "R1 data read locked");
    rdPort(IDX, 8'hFF, "R1 index read locked");

    // R4 key bytes on the data port do nothing
    sendKey(DAT);
    rdPort(IDX, 8'hFF, "R4 data writes do not unlock");
    rdPort(DAT, 8'hFF, "R4 data read locked");

    // R9 key on a foreign address does nothing, foreign read has no valid
    sendKey(FAR);
    rdPort(IDX, 8'hFF, "R9 foreign key ignored");
    @(negedge clk);
    busAddr = FAR; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    check("R9 foreign read no valid", {7'd0, rdValid}, 8'd0);

    // vector table: R2 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [15:0] a;
      a = VEC[i][16] ? DAT : IDX;
      if (VEC[i][17]) wrPort(a, VEC[i][15:8]);
      else rdPort(a, VEC[i][7:0], $sformatf("R5/R6/R7 table row %0d", i));
    end

    // R11 a wrong value at the exit register keeps the space open
    wrPort(IDX, 8'h02);
    wrPort(DAT, 8'h03);
    rdPort(IDX, 8'h02, "R11 still unlocked");

    // R8 exit relocks
    wrPort(DAT, 8'h02);
    rdPort(IDX, 8'hFF, "R8 relocked index read");
    rdPort(DAT, 8'hFF, "R8 relocked data read");

    // R3 broken sequence does not unlock
    wrPort(IDX, 8'h87); wrPort(IDX, 8'h01); wrPort(IDX, 8'h55); wrPort(IDX, 8'h00);
    rdPort(IDX, 8'hFF, "R3 broken key stays locked");
    // R3 restart on 0x87 counts as first byte
    wrPort(IDX, 8'h87); wrPort(IDX, 8'h01);
    sendKey(IDX);
    rdPort(IDX, 8'h00, "R3/R8 unlocked with cleared index");

    // R6 selector kept across relock, R7 bank contents kept
    wrPort(IDX, 8'h07);
    rdPort(DAT, 8'h03, "R6 selector retained");
    wrPort(IDX, 8'h30);
    rdPort(DAT, 8'hA5, "R7 bank retained");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule